// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Sequencer

This block sits behind a dual-purpose board pin. At power-up the pin acts as an active-low "supply good" strobe. Once the local supply has been good for a programmable settling time, the first low level seen on the pin captures the frequency-select straps (three select bits plus a table-select bit). That capture happens only once. From then on the pin acts as an active-high power-down request, and the straps no longer matter. The captured straps are decoded into a two-bit CPU frequency code through one of two lookup tables. They are also presented as a 4-bit readback field for a register file.

After capture the block runs a power-up delay and then enables every clock output. A power-down request must be seen high on two consecutive strobes that mark rising edges of the CPU complement clock before it is accepted. After that:

- Single-ended outputs park low on their next falling-edge strobe.
- Differential groups park on their next falling-edge strobe. Each group either holds high or floats, according to its own drive-mode input.
- The PLL enable drops only once every output is parked.

Releasing the pin re-runs the power-up delay. Analog parts are modelled as enables. All asynchronous pins pass through a two-stage synchronizer.

Top module: `pwrgood_pd_ctrl`

## Requirements
- R1: Straps are captured exactly once, on the first low pin level seen after settling. Later changes on the straps, and short pin pulses without sample strobes, leave the readback, the frequency code and the running outputs unchanged.
- R2: With the pin already low, `straps_valid` rises on the (DELAY_CYC+3)-th rising clock edge after `supply_ok` is presented high. This count includes two synchronizer stages.
- R3: With table-select 0, `strap_sel` = {C,B,A} decodes as follows, with `freq_code` 0=100 MHz, 1=133 MHz, 2=200 MHz, 3=266 MHz:
  - 101 gives 0
  - 001 gives 1
  - 010 gives 2
  - 000 gives 3
- R4: With table-select 1, only {B,A} = `strap_sel[1:0]` is used: 00 gives 0, 01 gives 1, 10 gives 2. Bit C has no effect, and code 3 is never produced.
- R5: Any combination not listed in R3 or R4 (111 is reserved, the others are undefined) sets `freq_err` to 1 and forces `freq_code` to 0.
- R6: `strap_rb` holds {table-select, C, B, A} in bits 3 down to 0. It reads zero before capture.
- R7: A power-down request is accepted only after `pd_sample_stb` sees the synchronized pin high on 2 consecutive strobes. A strobe that sees it low restarts the count.
- R8: After acceptance, `se_run` falls on the first `se_fall_stb` and not before.
- R9: After acceptance, all `dif_run` bits fall on the first `dif_fall_stb`. At that edge each `dif_hiz` bit takes the group's `dif_tristate_mode` bit: 1 means float, 0 means held high.
- R10: `pll_en` falls only after every output is parked, and it stays low while powered down.
- R11: All outputs are re-enabled WAKE_CYC+1 edges after capture. After a release they are re-enabled on the (WAKE_CYC+4)-th edge after the pin is presented low. `dif_hiz` clears at the same edge.
- R12: During and after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Local supply good (asynchronous) |
| pg_pd_pin | input | 1 | Power-good (active low) before capture, power-down (active high) after |
| strap_sel | input | 3 | Select straps {C,B,A} |
| strap_tbl | input | 1 | Table-select strap |
| pd_sample_stb | input | 1 | One-cycle mark of a CPU complement clock rising edge |
| se_fall_stb | input | 1 | One-cycle mark of a single-ended output falling edge |
| dif_fall_stb | input | 1 | One-cycle mark of a differential complement falling edge |
| dif_tristate_mode | input | NGRP | Per group: 1 float when parked, 0 hold high |
| pll_en | output | 1 | PLL and oscillator enable |
| se_run | output | 1 | Single-ended outputs toggling |
| dif_run | output | NGRP | Differential group toggling |
| dif_hiz | output | NGRP | Differential group floated while parked |
| straps_valid | output | 1 | Straps have been captured |
| strap_rb | output | 4 | Captured {table-select, C, B, A} |
| freq_code | output | 2 | Decoded CPU frequency code |
| freq_err | output | 1 | Strap combination is reserved or undefined |

## Verification
The in-RTL properties check these on every cycle:

- The captured straps never move once valid.
- The 2-bit table never yields the highest code.
- An error forces code 0.
- Each output can only stop on its own falling-edge strobe.
- The PLL never turns off with an output still running.
- Park is never entered without a completed run of high-sampled strobes.

Only the bench scenarios can show the rest:

- The exact settle and wake latencies.
- The full decode over all sixteen strap patterns.
- The debounce restart.
- Per-group float-versus-hold selection.
- Immunity to strap and pin activity after capture.

// File: rtl/pgpd_pkg.sv
package pgpd_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_ARM    = 3'd1,
    ST_WAKE   = 3'd2,
    ST_RUN    = 3'd3,
    ST_PARK   = 3'd4,
    ST_OFF    = 3'd5
  } seq_state_t;

  localparam logic [1:0] FRQ_100 = 2'd0;
  localparam logic [1:0] FRQ_133 = 2'd1;
  localparam logic [1:0] FRQ_200 = 2'd2;
  localparam logic [1:0] FRQ_266 = 2'd3;

  typedef struct packed {
    logic       tbl;
    logic [2:0] sel;
  } strap_t;

  // returns {err, code}
  function automatic logic [2:0] decode_straps(input strap_t s);
    logic [2:0] r;
    r = {1'b1, FRQ_100};
    if (!s.tbl) begin
      case (s.sel)
        3'b101:  r = {1'b0, FRQ_100};
        3'b001:  r = {1'b0, FRQ_133};
        3'b010:  r = {1'b0, FRQ_200};
        3'b000:  r = {1'b0, FRQ_266};
        default: r = {1'b1, FRQ_100};
      endcase
    end else begin
      case (s.sel[1:0])
        2'b00:   r = {1'b0, FRQ_100};
        2'b01:   r = {1'b0, FRQ_133};
        2'b10:   r = {1'b0, FRQ_200};
        default: r = {1'b1, FRQ_100};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/pgpd_sync.sv
module pgpd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/pgpd_strap_latch.sv
module pgpd_strap_latch
  import pgpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_stb,
  input  strap_t     straps_s,
  output logic       valid,
  output logic [3:0] rb,
  output logic [1:0] code,
  output logic       err
);

  logic [2:0] dec;
  assign dec = decode_straps(straps_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rb    <= '0;
      code  <= FRQ_100;
      err   <= 1'b0;
    end else if (cap_stb && !valid) begin
      valid <= 1'b1;
      rb    <= straps_s;
      code  <= dec[1:0];
      err   <= dec[2];
    end
  end

  // R1: once captured, the latched straps and decode never change
  p_latch_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    valid |=> (valid && $stable(rb) && $stable(code) && $stable(err)));

  // R5: an error always carries code 0
  p_err_code_zero_r5: assert property (@(posedge clk) disable iff (rst)
    err |-> (code == FRQ_100));

endmodule

// File: rtl/pgpd_pd_seq.sv
module pgpd_pd_seq
  import pgpd_pkg::*;
#(
  parameter int DELAY_CYC = 3580,
  parameter int WAKE_CYC  = 25000,
  parameter int PD_HITS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_s,
  input  logic pin_s,
  input  logic pd_stb,
  input  logic all_parked,
  output logic cap_stb,
  output logic in_run,
  output logic in_park,
  output logic pll_en
);

  localparam int MAXC  = (DELAY_CYC > WAKE_CYC) ? DELAY_CYC : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int HIT_W = $clog2(PD_HITS + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] WAK_LAST = CNT_W'(WAKE_CYC - 1);
  localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(PD_HITS - 1);

  seq_state_t       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [HIT_W-1:0] hits;
  logic             cnt_clr, cnt_inc;

  always_comb begin
    nxt     = state;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (state)
      ST_SETTLE: begin
        if (!sup_s)                 cnt_clr = 1'b1;
        else if (cnt == DLY_LAST) begin
          nxt = ST_ARM;  cnt_clr = 1'b1;
        end else                    cnt_inc = 1'b1;
      end
      ST_ARM: begin
        if (!sup_s) begin
          nxt = ST_SETTLE; cnt_clr = 1'b1;
        end else if (!pin_s) begin
          nxt = ST_WAKE;   cnt_clr = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cnt == WAK_LAST) begin
          nxt = ST_RUN; cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_RUN:  if (pd_stb && pin_s && (hits == HIT_LAST)) nxt = ST_PARK;
      ST_PARK: if (all_parked) nxt = ST_OFF;
      ST_OFF: begin
        if (!pin_s) begin
          nxt = ST_WAKE; cnt_clr = 1'b1;
        end
      end
      default: nxt = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SETTLE;
      cnt    <= '0;
      hits   <= '0;
      pll_en <= 1'b0;
    end else begin
      state  <= nxt;
      if (cnt_clr)      cnt <= '0;
      else if (cnt_inc) cnt <= cnt + 1'b1;
      if (state != ST_RUN) hits <= '0;
      else if (pd_stb)     hits <= pin_s ? ((hits == HIT_LAST) ? hits : hits + 1'b1) : '0;
      pll_en <= (nxt == ST_WAKE) || (nxt == ST_RUN) || (nxt == ST_PARK);
    end
  end

  assign cap_stb = (state == ST_ARM) && sup_s && !pin_s;
  assign in_run  = (state == ST_RUN);
  assign in_park = (state == ST_PARK);

  // R7: park is only entered from a strobe that saw the request high after enough hits
  p_park_needs_hits_r7: assert property (@(posedge clk) disable iff (rst)
    (in_park && $past(state) == ST_RUN) |-> $past(pd_stb && pin_s && hits == HIT_LAST));

  // R10: the PLL is off in the powered-down state
  p_pll_off_when_down_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFF && $past(state) == ST_OFF) |-> !pll_en);

endmodule

// File: rtl/pgpd_out_park.sv
module pgpd_out_park #(
  parameter int NGRP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_run,
  input  logic            in_park,
  input  logic            se_stb,
  input  logic            dif_stb,
  input  logic [NGRP-1:0] dm,
  output logic            se_run,
  output logic [NGRP-1:0] dif_run,
  output logic [NGRP-1:0] dif_hiz,
  output logic            all_parked
);

  always_ff @(posedge clk) begin
    if (rst)          se_run <= 1'b0;
    else if (in_run)  se_run <= 1'b1;
    else if (in_park) begin
      if (se_stb) se_run <= 1'b0;
    end else          se_run <= 1'b0;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_dif
    always_ff @(posedge clk) begin
      if (rst) begin
        dif_run[g] <= 1'b0;
        dif_hiz[g] <= 1'b0;
      end else if (in_run) begin
        dif_run[g] <= 1'b1;
        dif_hiz[g] <= 1'b0;
      end else if (in_park) begin
        if (dif_stb && dif_run[g]) begin
          dif_run[g] <= 1'b0;
          dif_hiz[g] <= dm[g];
        end
      end else begin
        dif_run[g] <= 1'b0;
      end
    end

    // R9: a differential group only stops on its falling-edge strobe
    p_dif_stop_on_edge_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(dif_run[g]) |-> $past(dif_stb));
  end

  assign all_parked = !se_run && (dif_run == '0);

  // R8: single-ended outputs only stop on their falling-edge strobe
  p_se_stop_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(se_run) |-> $past(se_stb));

endmodule

// File: rtl/pwrgood_pd_ctrl.sv
module pwrgood_pd_ctrl
  import pgpd_pkg::*;
#(
  parameter int NGRP      = 2,
  parameter int DELAY_CYC = 3580,
  parameter int WAKE_CYC  = 25000,
  parameter int PD_HITS   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            supply_ok,
  input  logic            pg_pd_pin,
  input  logic [2:0]      strap_sel,
  input  logic            strap_tbl,
  input  logic            pd_sample_stb,
  input  logic            se_fall_stb,
  input  logic            dif_fall_stb,
  input  logic [NGRP-1:0] dif_tristate_mode,
  output logic            pll_en,
  output logic            se_run,
  output logic [NGRP-1:0] dif_run,
  output logic [NGRP-1:0] dif_hiz,
  output logic            straps_valid,
  output logic [3:0]      strap_rb,
  output logic [1:0]      freq_code,
  output logic            freq_err
);

  localparam int SW = 6;
  localparam logic [SW-1:0] SYNC_RST = 6'b010000;

  logic [SW-1:0] raw_s;
  logic          sup_s, pin_s, cap_stb, in_run, in_park, all_parked;
  strap_t        straps_s;

  pgpd_sync #(.W(SW), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({supply_ok, pg_pd_pin, strap_tbl, strap_sel}),
    .q   (raw_s)
  );

  assign sup_s    = raw_s[5];
  assign pin_s    = raw_s[4];
  assign straps_s = raw_s[3:0];

  pgpd_strap_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (cap_stb),
    .straps_s(straps_s),
    .valid   (straps_valid),
    .rb      (strap_rb),
    .code    (freq_code),
    .err     (freq_err)
  );

  pgpd_pd_seq #(.DELAY_CYC(DELAY_CYC), .WAKE_CYC(WAKE_CYC), .PD_HITS(PD_HITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sup_s     (sup_s),
    .pin_s     (pin_s),
    .pd_stb    (pd_sample_stb),
    .all_parked(all_parked),
    .cap_stb   (cap_stb),
    .in_run    (in_run),
    .in_park   (in_park),
    .pll_en    (pll_en)
  );

  pgpd_out_park #(.NGRP(NGRP)) u_park (
    .clk       (clk),
    .rst       (rst),
    .in_run    (in_run),
    .in_park   (in_park),
    .se_stb    (se_fall_stb),
    .dif_stb   (dif_fall_stb),
    .dm        (dif_tristate_mode),
    .se_run    (se_run),
    .dif_run   (dif_run),
    .dif_hiz   (dif_hiz),
    .all_parked(all_parked)
  );

  // R4: the two-bit table never yields the 266 MHz code
  p_tbl1_no_top_code_r4: assert property (@(posedge clk) disable iff (rst)
    (straps_valid && strap_rb[3]) |-> (freq_code != FRQ_266));

  // R10: the PLL never turns off while an output still runs
  p_pll_off_after_park_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en) |-> (!se_run && dif_run == '0));

  // R11: outputs only run with the PLL on
  p_run_needs_pll_r11: assert property (@(posedge clk) disable iff (rst)
    se_run |-> pll_en);

endmodule

// File: tb/sim_pwrgood_pd_ctrl.sv
module sim_pwrgood_pd_ctrl;

  localparam int NGRP = 2;
  localparam int DLY  = 8;
  localparam int WAK  = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            supply_ok = 1'b0;
  logic            pg_pd_pin = 1'b1;
  logic [2:0]      strap_sel = 3'b000;
  logic            strap_tbl = 1'b0;
  logic            pd_sample_stb = 1'b0;
  logic            se_fall_stb = 1'b0;
  logic            dif_fall_stb = 1'b0;
  logic [NGRP-1:0] dif_tristate_mode = '0;
  logic            pll_en, se_run, straps_valid, freq_err;
  logic [NGRP-1:0] dif_run, dif_hiz;
  logic [3:0]      strap_rb;
  logic [1:0]      freq_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwrgood_pd_ctrl #(.NGRP(NGRP), .DELAY_CYC(DLY), .WAKE_CYC(WAK), .PD_HITS(2)) u0 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .pg_pd_pin(pg_pd_pin),
    .strap_sel(strap_sel), .strap_tbl(strap_tbl), .pd_sample_stb(pd_sample_stb),
    .se_fall_stb(se_fall_stb), .dif_fall_stb(dif_fall_stb),
    .dif_tristate_mode(dif_tristate_mode), .pll_en(pll_en), .se_run(se_run),
    .dif_run(dif_run), .dif_hiz(dif_hiz), .straps_valid(straps_valid),
    .strap_rb(strap_rb), .freq_code(freq_code), .freq_err(freq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // expected {err, code} from the requirement tables
  function automatic logic [2:0] exp_dec(input logic [3:0] s);
    logic [2:0] abc;
    abc = s[2:0];
    if (!s[3]) begin
      if (abc == 3'b101)      return 3'b000;
      else if (abc == 3'b001) return 3'b001;
      else if (abc == 3'b010) return 3'b010;
      else if (abc == 3'b000) return 3'b011;
      else                    return 3'b100;
    end else begin
      if (abc[1:0] == 2'b11)  return 3'b100;
      else                    return {1'b0, abc[1:0]};
    end
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; supply_ok = 1'b0; pg_pd_pin = 1'b1;
    pd_sample_stb = 1'b0; se_fall_stb = 1'b0; dif_fall_stb = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  // straps set, pin low, then supply raised; measures capture and wake latency
  task automatic bring_up(input logic [3:0] s);
    int n;
    strap_tbl = s[3]; strap_sel = s[2:0]; pg_pd_pin = 1'b0;
    cyc(3);
    supply_ok = 1'b1;
    n = 0;
    while (!straps_valid && n < 200) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == DLY + 3, "R2 settle-to-capture edges", n, DLY + 3);
    n = 0;
    while (!se_run && n < 200) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == WAK + 1, "R11 capture-to-run edges", n, WAK + 1);
    chk(dif_run == '1, "R11 dif_run after wake", int'(dif_run), 3);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk); cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] e;
    int n;
    // R12: reset state
    cyc(2);
    chk(!se_run && !pll_en && dif_run == 0 && dif_hiz == 0, "R12 outputs in reset",
        int'({se_run, pll_en, dif_run, dif_hiz}), 0);
    chk(!straps_valid && strap_rb == 0 && !freq_err && freq_code == 0, "R12 R6 readback zero",
        int'({straps_valid, strap_rb, freq_err, freq_code}), 0);
    do_reset();
    cyc(2);
    chk(!se_run && !pll_en && strap_rb == 0, "R12 after reset", int'({se_run, pll_en, strap_rb}), 0);

    // R3 R4 R5 R6: full strap sweep
    for (int s = 0; s < 16; s++) begin
      do_reset();
      bring_up(4'(s));
      e = exp_dec(4'(s));
      chk(strap_rb == 4'(s), "R6 readback {tbl,C,B,A}", int'(strap_rb), s);
      chk(freq_err == e[2], s[3] ? "R4 R5 table1 err" : "R3 R5 table0 err", int'(freq_err), int'(e[2]));
      chk(freq_code == e[1:0], s[3] ? "R4 table1 code" : "R3 table0 code", int'(freq_code), int'(e[1:0]));
    end

    // R1: one-shot capture, later strap and short pin activity ignored
    do_reset();
    bring_up(4'b0001);
    strap_tbl = 1'b1; strap_sel = 3'b110;
    cyc(4);
    pg_pd_pin = 1'b1; cyc(1); pg_pd_pin = 1'b0;
    cyc(6);
    chk(strap_rb == 4'b0001, "R1 readback held", int'(strap_rb), 1);
    chk(freq_code == 2'd1 && !freq_err, "R1 code held", int'(freq_code), 1);
    chk(se_run && pll_en, "R1 outputs keep running", int'(se_run), 1);

    // power-down cycles with two drive-mode patterns
    for (int k = 0; k < 2; k++) begin
      dif_tristate_mode = (k == 0) ? 2'b10 : 2'b01;
      pg_pd_pin = 1'b1; cyc(4);
      chk(se_run, "R7 no strobe no park", int'(se_run), 1);
      pulse(pd_sample_stb); cyc(2);
      chk(se_run && pll_en, "R7 one hit no park", int'(se_run), 1);
      pg_pd_pin = 1'b0; cyc(4); pulse(pd_sample_stb);
      pg_pd_pin = 1'b1; cyc(4); pulse(pd_sample_stb); cyc(2);
      chk(se_run, "R7 low strobe restarts count", int'(se_run), 1);
      pulse(pd_sample_stb); cyc(3);
      chk(se_run && pll_en, "R8 se holds until its edge", int'(se_run), 1);
      chk(dif_run == 2'b11, "R9 dif holds until its edge", int'(dif_run), 3);
      pulse(se_fall_stb);
      chk(!se_run, "R8 se parked on edge", int'(se_run), 0);
      chk(dif_run == 2'b11 && pll_en, "R10 pll held with dif running", int'(pll_en), 1);
      pulse(dif_fall_stb);
      chk(dif_run == 0, "R9 dif parked on edge", int'(dif_run), 0);
      chk(dif_hiz == dif_tristate_mode, "R9 hiz per drive mode", int'(dif_hiz), int'(dif_tristate_mode));
      cyc(2);
      chk(!pll_en, "R10 pll off after park", int'(pll_en), 0);
      cyc(5);
      chk(!pll_en && !se_run, "R10 stays down", int'({pll_en, se_run}), 0);
      @(negedge clk); pg_pd_pin = 1'b0;
      n = 0;
      while (!se_run && n < 200) begin
        @(posedge clk); n++; @(negedge clk);
      end
      chk(n == WAK + 4, "R11 release-to-run edges", n, WAK + 4);
      chk(dif_run == 2'b11 && dif_hiz == 0, "R11 dif restored", int'({dif_run, dif_hiz}), 12);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule